// File: doc/BRIEF.md
# Self-Repairing Seconds/Minutes Counter Array

This block is a row of identical counting cells that together keep a minutes-and-seconds clock. Four cells are needed to hold the four digits: seconds units, seconds tens, minutes units and minutes tens. One or more extra cells wait at the high end of the row as spares. Each cell holds every counting behaviour of the clock, which is a wrap at ten for a units digit and a wrap at six for a tens digit. A cell runs only the behaviour chosen by its coordinate. The coordinate is the number of healthy cells to its left.

When a cell is reported faulty, it is marked dead for good. Every healthy cell to its right then gets a coordinate one lower and takes over the role of its left neighbour. On the same clock edge, the digit values move into the cells that now hold each role, so the time shown does not change. Dead cells pass the carry along the row. When more cells are dead than there are spares, the array raises an unrecoverable flag and freezes the count.

Top module: `genome_clock_array`

## Requirements
- R1: While reset is low and right after it, digits_o is all zero, repair_o is 0 and fail_o is 0.
- R2: digits_o packs the roles in DIGIT_W-bit fields. Bits [3:0] hold seconds units, [7:4] seconds tens, [11:8] minutes units and [15:12] minutes tens. Each rising edge with tick=1 advances seconds units 0..9, wrapping 9 to 0. An edge with tick=0 leaves every digit unchanged.
- R3: Seconds tens counts 0..5 and advances only on an edge where seconds units wraps from 9 to 0.
- R4: Minutes units (0..9) advances when the seconds reach 59 and wrap. Minutes tens (0..5) advances when minutes units wraps. The tick after 59:59 gives 00:00.
- R5: When fault_i bit i (bit i = cell i, cell 0 at the low end) marks a working cell dead, digits_o keeps its value on that edge if tick=0. Counting then goes on from the preserved value, exactly as in a fault-free array.
- R6: repair_o goes to 1 on the edge that accepts the first dead cell and stays at 1 until reset.
- R7: A fault on a cell that is already dead has no effect. A fault on an unused spare leaves digits_o unchanged but sets repair_o.
- R8: On an edge where the dead cells would outnumber NUM_SPARES, fail_o goes to 1 and the set of dead cells stays as it was. From then until reset, digits_o is frozen: the tick on that edge and all later ticks and faults are ignored.
- R9: A fault accepted on the same edge as a tick both remaps the roles and applies the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Advance the count by one second on this edge |
| fault_i | input | NUM_ROLES+NUM_SPARES | Per-cell fault report, bit i for cell i |
| digits_o | output | NUM_ROLES*DIGIT_W | Role-ordered digit values |
| repair_o | output | 1 | At least one cell is dead and a spare is in use |
| fail_o | output | 1 | Dead cells exceeded the spares; count frozen |

## Verification
The assertions assume that tick and fault_i are plain levels sampled at each rising edge. They also assume that nothing during reset carries over into the first checked cycle, so the step properties compare against the previous digit value only while the array runs. The bench keeps tick and fault_i low during reset and changes them only at falling edges. It injects faults rarely in the random phase so that long stretches of repaired counting happen before the spares run out. Directed runs cover the remaining cases: the full hour wrap, a fault on a dead cell or on the spare, and a fault that coincides with a tick.

// File: rtl/genome_clock_pkg.sv
`timescale 1ns/1ps
package genome_clock_pkg;
   // Genome of the clock: even roles are units digits, odd roles are tens digits.
   function automatic int unsigned gene_modulus(input int unsigned role);
      return (role % 2 == 0) ? 10 : 6;
   endfunction
endpackage

// File: rtl/gc_coord_unit.sv
`timescale 1ns/1ps
module gc_coord_unit #(
   parameter int NCELL = 5,
   parameter int CW    = 3
) (
   input  logic [NCELL-1:0]         dead,
   output logic [NCELL-1:0][CW-1:0] coord
);
   // Coordinate of a cell = healthy cells strictly to its left.
   always_comb begin
      logic [CW-1:0] acc;
      acc = '0;
      for (int i = 0; i < NCELL; i++) begin
         coord[i] = acc;
         if (!dead[i]) acc = acc + 1'b1;
      end
   end
endmodule

// File: rtl/gc_gene_cell.sv
`timescale 1ns/1ps
module gc_gene_cell
   import genome_clock_pkg::*;
#(
   parameter int NROLE = 4,
   parameter int DW    = 4,
   parameter int CW    = 3
) (
   input  logic [DW-1:0] digit,
   input  logic [CW-1:0] coord,
   input  logic          dead,
   input  logic          cin,
   output logic [DW-1:0] digit_nx,
   output logic          cout
);
   // Every cell carries the full genome: the last value of each role.
   logic [NROLE-1:0][DW-1:0] gene_last;
   generate
      for (genvar g = 0; g < NROLE; g++) begin : g_genome
         assign gene_last[g] = DW'(gene_modulus(g) - 1);
      end
   endgenerate

   logic          active;
   logic [DW-1:0] last;

   always_comb begin
      active = !dead && (coord < CW'(NROLE));
      last   = '0;
      for (int g = 0; g < NROLE; g++)
         if (coord == CW'(g)) last = gene_last[g];
      digit_nx = digit;
      cout     = cin;              // dead or idle cells pass the carry on
      if (active) begin
         cout = cin && (digit == last);
         if (cin) digit_nx = (digit == last) ? '0 : digit + 1'b1;
      end
   end
endmodule

// File: rtl/gc_role_router.sv
`timescale 1ns/1ps
module gc_role_router #(
   parameter int NCELL = 5,
   parameter int NROLE = 4,
   parameter int DW    = 4,
   parameter int CW    = 3
) (
   input  logic [NCELL-1:0][DW-1:0] cell_val,
   input  logic [NCELL-1:0][CW-1:0] coord,
   input  logic [NCELL-1:0]         dead,
   output logic [NROLE-1:0][DW-1:0] role_val
);
   always_comb begin
      role_val = '0;
      for (int r = 0; r < NROLE; r++)
         for (int c = 0; c < NCELL; c++)
            if (!dead[c] && coord[c] == CW'(r)) role_val[r] = cell_val[c];
   end
endmodule

// File: rtl/genome_clock_array.sv
`timescale 1ns/1ps
module genome_clock_array #(
   parameter int NUM_ROLES  = 4,
   parameter int NUM_SPARES = 1,
   parameter int DIGIT_W    = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            tick,
   input  logic [NUM_ROLES+NUM_SPARES-1:0] fault_i,
   output logic [NUM_ROLES*DIGIT_W-1:0]    digits_o,
   output logic                            repair_o,
   output logic                            fail_o
);
   localparam int NUM_CELLS = NUM_ROLES + NUM_SPARES;
   localparam int CW        = $clog2(NUM_CELLS + 1);

   generate
      if (DIGIT_W < 4) begin : g_bad_width
         $error("DIGIT_W must hold a digit up to 9");
      end
      if (NUM_ROLES < 1) begin : g_bad_roles
         $error("NUM_ROLES must be at least 1");
      end
      if (NUM_SPARES < 1) begin : g_bad_spares
         $error("NUM_SPARES must be at least 1");
      end
   endgenerate

   logic [NUM_CELLS-1:0]              dead_q, fault_n, dead_acc;
   logic                              fail_q, over;
   logic [NUM_CELLS-1:0][DIGIT_W-1:0] digit_q, digit_nx, reload;
   logic [NUM_CELLS-1:0][CW-1:0]      coord_cur, coord_nxt;
   logic [NUM_ROLES-1:0][DIGIT_W-1:0] role_now, role_next;
   logic [NUM_CELLS:0]                carry;
   logic                              rollover;

   assign fault_n  = dead_q | fault_i;
   assign over     = $countones(fault_n) > NUM_SPARES;
   assign dead_acc = over ? dead_q : fault_n;

   gc_coord_unit #(.NCELL(NUM_CELLS), .CW(CW)) u_coord_cur (
      .dead(dead_q), .coord(coord_cur));
   gc_coord_unit #(.NCELL(NUM_CELLS), .CW(CW)) u_coord_nxt (
      .dead(dead_acc), .coord(coord_nxt));

   assign carry[0] = tick;
   generate
      for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
         gc_gene_cell #(.NROLE(NUM_ROLES), .DW(DIGIT_W), .CW(CW)) u_cell (
            .digit   (digit_q[i]),
            .coord   (coord_cur[i]),
            .dead    (dead_q[i]),
            .cin     (carry[i]),
            .digit_nx(digit_nx[i]),
            .cout    (carry[i+1]));
      end
   endgenerate
   assign rollover = carry[NUM_CELLS];

   gc_role_router #(.NCELL(NUM_CELLS), .NROLE(NUM_ROLES), .DW(DIGIT_W), .CW(CW))
      u_route_now (.cell_val(digit_q), .coord(coord_cur), .dead(dead_q),
                   .role_val(role_now));
   gc_role_router #(.NCELL(NUM_CELLS), .NROLE(NUM_ROLES), .DW(DIGIT_W), .CW(CW))
      u_route_next (.cell_val(digit_nx), .coord(coord_cur), .dead(dead_q),
                    .role_val(role_next));

   // Each cell loads the next value of the role it holds under the new mask.
   always_comb begin
      reload = '0;
      for (int c = 0; c < NUM_CELLS; c++)
         for (int r = 0; r < NUM_ROLES; r++)
            if (!dead_acc[c] && coord_nxt[c] == CW'(r)) reload[c] = role_next[r];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dead_q  <= '0;
         fail_q  <= 1'b0;
         digit_q <= '0;
      end else if (!fail_q) begin
         if (over) begin
            fail_q <= 1'b1;
         end else begin
            dead_q  <= fault_n;
            digit_q <= reload;
         end
      end
   end

   generate
      for (genvar r = 0; r < NUM_ROLES; r++) begin : g_out
         assign digits_o[r*DIGIT_W +: DIGIT_W] = role_now[r];
      end
   endgenerate
   assign repair_o = |dead_q;
   assign fail_o   = fail_q;
endmodule

// File: rtl/gc_checker.sv
`timescale 1ns/1ps
module gc_checker
   import genome_clock_pkg::*;
#(
   parameter int NUM_ROLES = 4,
   parameter int DIGIT_W   = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         tick,
   input logic [NUM_ROLES*DIGIT_W-1:0] digits_o,
   input logic                         repair_o,
   input logic                         fail_o,
   input logic                         rollover
);
   localparam logic [DIGIT_W-1:0] UNITS_LAST = DIGIT_W'(gene_modulus(0) - 1);
   logic [DIGIT_W-1:0] units;
   assign units = digits_o[DIGIT_W-1:0];

   // Every role stays inside its own modulus (R2, R3, R4).
   generate
      for (genvar r = 0; r < NUM_ROLES; r++) begin : g_range
         assert_digit_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
            digits_o[r*DIGIT_W +: DIGIT_W] < DIGIT_W'(gene_modulus(r)));
      end
   endgenerate

   assert_units_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !fail_o |=> fail_o ||
         units == (($past(units) == UNITS_LAST) ? '0 : $past(units) + 1'b1));

   assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(digits_o));

   assert_full_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rollover && !fail_o |=> fail_o || digits_o == '0);

   assert_repair_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      repair_o |=> repair_o);

   assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |=> fail_o);

   assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |=> $stable(digits_o));
endmodule

bind genome_clock_array gc_checker #(.NUM_ROLES(NUM_ROLES), .DIGIT_W(DIGIT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .digits_o(digits_o),
   .repair_o(repair_o), .fail_o(fail_o), .rollover(rollover));

// File: tb/genome_clock_array_test.sv
`timescale 1ns/1ps
module genome_clock_array_test;
   localparam int NR = 4;
   localparam int NS = 1;
   localparam int NC = NR + NS;
   localparam int DW = 4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               tick = 1'b0;
   logic [NC-1:0]      fault_i = '0;
   logic [NR*DW-1:0]   digits_o;
   logic               repair_o, fail_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   int m_dig [NR];
   logic [NC-1:0] m_mask;
   bit m_fail;

   always #2 clk = ~clk;

   genome_clock_array #(.NUM_ROLES(NR), .NUM_SPARES(NS), .DIGIT_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .fault_i(fault_i),
      .digits_o(digits_o), .repair_o(repair_o), .fail_o(fail_o));

   function automatic int mod_of(input int r);
      return (r % 2 == 0) ? 10 : 6;
   endfunction

   function automatic logic [NR*DW-1:0] exp_digits();
      logic [NR*DW-1:0] v = '0;
      for (int r = 0; r < NR; r++) v[r*DW +: DW] = DW'(m_dig[r]);
      return v;
   endfunction

   task automatic model_edge(input bit t, input logic [NC-1:0] f);
      logic [NC-1:0] nm;
      bit c;
      if (m_fail) return;
      nm = m_mask | f;
      if ($countones(nm) > NS) begin
         m_fail = 1;
         return;
      end
      m_mask = nm;
      c = t;
      for (int r = 0; r < NR; r++) begin
         if (c) begin
            if (m_dig[r] == mod_of(r) - 1) m_dig[r] = 0;
            else begin m_dig[r] = m_dig[r] + 1; c = 0; end
         end
      end
   endtask

   task automatic check(input string tag);
      logic [NR*DW-1:0] e;
      e = exp_digits();
      checks++;
      if (digits_o !== e || repair_o !== (m_mask != 0) || fail_o !== m_fail) begin
         failures++;
         $display("FAIL %s: digits=%h repair=%b fail=%b expected digits=%h repair=%b fail=%b",
                  tag, digits_o, repair_o, fail_o, e, (m_mask != 0), m_fail);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; tick = 0; fault_i = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      for (int r = 0; r < NR; r++) m_dig[r] = 0;
      m_mask = '0; m_fail = 0;
   endtask

   // Drive at the falling edge, model the rising edge, sample at the next falling edge.
   task automatic step(input bit t, input logic [NC-1:0] f, input string tag);
      tick = t; fault_i = f;
      @(posedge clk);
      model_edge(t, f);
      @(negedge clk);
      tick = 0; fault_i = '0;
      check(tag);
   endtask

   task automatic finish_run();
      if (done) return;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      process::self().srandom(32'd566);
      do_reset();
      check("R1");
      // R2 units counting and hold without tick
      for (int i = 0; i < 9; i++) step(1, '0, "R2");
      step(0, '0, "R2");
      step(0, '0, "R2");
      step(1, '0, "R3");                 // 9 -> 0, tens to 1
      for (int i = 0; i < 49; i++) step(1, '0, "R3");
      // R4 run up to 59:59 and wrap
      for (int i = 0; i < 3540; i++) step(1, '0, "R4");
      step(1, '0, "R4");                 // expected 00:00
      if (exp_digits() != '0) begin
         failures++;
         $display("FAIL R4: model=%h expected=0", exp_digits());
      end
      // R5 / R6 fault on an active cell, then keep counting
      for (int i = 0; i < 17; i++) step(1, '0, "R2");
      step(0, 5'b00010, "R5");
      step(0, '0, "R6");
      for (int i = 0; i < 60; i++) step(1, '0, "R5");
      // R7 repeated fault on dead cell
      step(0, 5'b00010, "R7");
      step(1, 5'b00010, "R7");
      // R8 second fault, tick on same edge ignored, frozen afterwards
      step(1, 5'b00100, "R8");
      for (int i = 0; i < 10; i++) step(1, 5'b01000, "R8");
      // R7 spare fault
      do_reset();
      for (int i = 0; i < 23; i++) step(1, '0, "R2");
      step(0, 5'b10000, "R7");
      for (int i = 0; i < 15; i++) step(1, '0, "R7");
      // R9 fault and tick together, faulty cell holding seconds units
      do_reset();
      for (int i = 0; i < 9; i++) step(1, '0, "R2");
      step(1, 5'b00001, "R9");
      for (int i = 0; i < 70; i++) step(1, '0, "R9");
      // R8 two faults at once from a clean array
      do_reset();
      for (int i = 0; i < 5; i++) step(1, '0, "R2");
      step(1, 5'b00011, "R8");
      step(1, '0, "R8");
      // random phase
      for (int k = 0; k < 3; k++) begin
         do_reset();
         for (int i = 0; i < 4000; i++) begin
            logic [NC-1:0] f;
            bit t;
            t = ($urandom % 2) == 1;
            f = '0;
            if (($urandom % 400) == 0) f[$urandom % NC] = 1'b1;
            step(t, f, m_fail ? "R8" : (m_mask != 0 ? "R5" : "R2"));
         end
      end
      finish_run();
   end
endmodule